// File: doc/BRIEF.md
# Watchpoint Address Register Bank

This block holds a bank of data-address registers for hardware watchpoints and serves them through a coprocessor-style system-register port. Each access arrives as a set of encoding fields: a coprocessor number, two opcode fields and two register-number fields. The block recognises the one encoding that names this bank and takes a 4-bit index from the secondary register field. From the current privilege level and a group of configuration inputs, it then decides whether the access completes, is refused as undefined, traps to a higher level with a syndrome code, or asks for a debug halt.

A completed write stores the address bits of the write data. The two lowest bits are never stored. A completed read returns the selected register on the same cycle. The bank has two resets. Cold reset loads a fixed pattern set by a parameter. Warm reset leaves the bank untouched. Comparing these addresses against data traffic is handled elsewhere.

Top module: `wpt_addr_bank`

## Requirements
- R1: An access is recognised (`acc_hit`=1) only when `acc_valid`=1, `acc_cp`=4'b1110, `acc_opc1`=0, `acc_crn`=0 and `acc_opc2`=3'b110. An unrecognised access drives `acc_outcome`=0, `acc_syndrome`=0 and `acc_rdata`=0, and changes no register.
- R2: A completed write stores write-data bits [31:2] into the register selected by `acc_crm`. Bits [1:0] of every read value are zero, whatever was written.
- R3: Outcome codes are 0 success, 1 undefined, 2 trap to level 2 (64-bit), 3 hypervisor trap (32-bit level 2), 4 trap to level 3, 5 debug halt. A recognised access with `acc_crm` >= NUM_REGS gives outcome 1 at every level.
- R4: A recognised access at privilege level 0 (`priv_lvl`=0) gives outcome 1.
- R5: At level 1 the checks apply in this order, and the first that holds wins. (a) `l2_enabled`, `l2_is_64` and `l2_trap_ctl`!=0 give 2. (b) `l2_enabled`, !`l2_is_64` and `l2_trap_ctl`!=0 give 3. (c) `l3_present`, `l3_is_64` and `l3_trap_bit` give 4. (d) `l1_is_32`, !`os_lock`, `halt_allowed` and `ext_trap_bit` give 5. If none holds, the result is 0.
- R6: At level 2 only checks (c) and then (d) apply, and the level-2 controls are ignored. At level 3 only check (d) applies.
- R7: `acc_syndrome` is 6'h05 for outcomes 2, 3 and 4, and 0 otherwise.
- R8: A register changes only on a clock edge where a recognised write has outcome 0. A write with any other outcome leaves the bank unchanged.
- R9: Reads are combinational. `acc_rdata` carries the selected register whenever the outcome is 0 and the access is recognised, and is 0 otherwise.
- R10: Asserting `warm_rst_n` low does not change the bank. Cold reset loads a fixed parameter pattern, and users must not rely on its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low; has no effect on the bank |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_cp | input | 4 | Coprocessor field |
| acc_opc1 | input | 3 | Primary opcode field |
| acc_crn | input | 4 | Primary register field |
| acc_crm | input | 4 | Secondary register field, register index |
| acc_opc2 | input | 3 | Secondary opcode field |
| acc_wdata | input | 32 | Write data |
| priv_lvl | input | 2 | Current privilege level 0..3 |
| l2_enabled | input | 1 | Level 2 is enabled |
| l2_is_64 | input | 1 | Level 2 runs in 64-bit state |
| l2_trap_ctl | input | 2 | Level-2 debug trap control pair |
| l3_present | input | 1 | Level 3 exists |
| l3_is_64 | input | 1 | Level 3 runs in 64-bit state |
| l3_trap_bit | input | 1 | Level-3 debug trap enable |
| l1_is_32 | input | 1 | Level 1 runs in 32-bit state |
| os_lock | input | 1 | OS lock is set |
| halt_allowed | input | 1 | Halting debug is allowed |
| ext_trap_bit | input | 1 | External debugger trap enable |
| acc_hit | output | 1 | Encoding recognised |
| acc_outcome | output | 3 | Outcome code (see R3) |
| acc_syndrome | output | 6 | Trap syndrome code |
| acc_rdata | output | 32 | Read data |

## Verification
The hardest case to reach is the priority ordering of the level-1 chain. Every rule holds only when an earlier rule does not, so each outcome appears only after the conditions of the rules above it are withdrawn. The stimulus first sets every condition true and then clears them one at a time from the top, checking each outcome in turn. The same fully set configuration is then reused at levels 2 and 3 to show that the higher-level rules are skipped. A refused write is only visible through a later successful read, so every failed write is followed by a read at level 1 with the traps cleared.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
    typedef enum logic [2:0] {
        OC_OK       = 3'd0,
        OC_UNDEF    = 3'd1,
        OC_TRAP_L2  = 3'd2,
        OC_TRAP_HYP = 3'd3,
        OC_TRAP_L3  = 3'd4,
        OC_HALT     = 3'd5
    } wpt_outcome_e;

    typedef struct packed {
        logic       l2_enabled;
        logic       l2_is_64;
        logic [1:0] l2_trap_ctl;
        logic       l3_present;
        logic       l3_is_64;
        logic       l3_trap_bit;
        logic       l1_is_32;
        logic       os_lock;
        logic       halt_allowed;
        logic       ext_trap_bit;
    } wpt_cfg_t;

    localparam int unsigned SYN_W    = 6;
    localparam logic [5:0]  SYN_TRAP = 6'h05;
endpackage

// File: rtl/wpt_decode.sv
module wpt_decode #(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned IDX_W    = 4
) (
    input  logic             valid_i,
    input  logic [3:0]       cp_i,
    input  logic [2:0]       opc1_i,
    input  logic [3:0]       crn_i,
    input  logic [IDX_W-1:0] crm_i,
    input  logic [2:0]       opc2_i,
    output logic             hit_o,
    output logic             idx_ok_o
);
    localparam logic [3:0] CP_SEL   = 4'b1110;
    localparam logic [2:0] OPC2_SEL = 3'b110;
    localparam int unsigned IDX_SPAN = 1 << IDX_W;

    always_comb begin
        hit_o = valid_i && (cp_i == CP_SEL) && (opc1_i == 3'd0)
                && (crn_i == 4'd0) && (opc2_i == OPC2_SEL);
    end

    generate
        if (NUM_REGS >= IDX_SPAN) begin : g_full
            assign idx_ok_o = 1'b1;
        end else begin : g_part
            assign idx_ok_o = ({1'b0, crm_i} < (IDX_W+1)'(NUM_REGS));
        end
    endgenerate
endmodule

// File: rtl/wpt_perm.sv
module wpt_perm
    import wpt_pkg::*;
(
    input  logic                  hit_i,
    input  logic                  idx_ok_i,
    input  logic [1:0]            priv_i,
    input  wpt_cfg_t              cfg_i,
    output wpt_outcome_e          outcome_o,
    output logic [SYN_W-1:0]      syndrome_o
);
    logic trap_l2_64, trap_l2_hyp, trap_l3, halt_req;

    always_comb begin
        trap_l2_64  = cfg_i.l2_enabled && cfg_i.l2_is_64  && (cfg_i.l2_trap_ctl != 2'b00);
        trap_l2_hyp = cfg_i.l2_enabled && !cfg_i.l2_is_64 && (cfg_i.l2_trap_ctl != 2'b00);
        trap_l3     = cfg_i.l3_present && cfg_i.l3_is_64 && cfg_i.l3_trap_bit;
        halt_req    = cfg_i.l1_is_32 && !cfg_i.os_lock && cfg_i.halt_allowed
                      && cfg_i.ext_trap_bit;
    end

    always_comb begin
        outcome_o = OC_OK;
        if (!hit_i) begin
            outcome_o = OC_OK;
        end else if (!idx_ok_i || priv_i == 2'd0) begin
            outcome_o = OC_UNDEF;
        end else begin
            unique case (priv_i)
                2'd1: begin
                    if (trap_l2_64)       outcome_o = OC_TRAP_L2;
                    else if (trap_l2_hyp) outcome_o = OC_TRAP_HYP;
                    else if (trap_l3)     outcome_o = OC_TRAP_L3;
                    else if (halt_req)    outcome_o = OC_HALT;
                end
                2'd2: begin
                    if (trap_l3)       outcome_o = OC_TRAP_L3;
                    else if (halt_req) outcome_o = OC_HALT;
                end
                default: begin
                    if (halt_req) outcome_o = OC_HALT;
                end
            endcase
        end
    end

    always_comb begin
        syndrome_o = '0;
        if (outcome_o == OC_TRAP_L2 || outcome_o == OC_TRAP_HYP || outcome_o == OC_TRAP_L3)
            syndrome_o = SYN_TRAP;
    end
endmodule

// File: rtl/wpt_regfile.sv
module wpt_regfile #(
    parameter int unsigned  NUM_REGS    = 16,
    parameter int unsigned  IDX_W       = 4,
    parameter int unsigned  DATA_W      = 32,
    parameter int unsigned  ADDR_LSB    = 2,
    parameter logic [31:0]  RST_PATTERN = 32'h0BAD_F00C
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned AW = DATA_W - ADDR_LSB;

    typedef struct packed {
        logic [NUM_REGS-1:0][AW-1:0] slot;
    } bank_t;

    bank_t             bank_d, bank_q;
    logic [NUM_REGS-1:0] sel;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
            assign sel[g] = (idx_i == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en_i && sel[i]) bank_d.slot[i] = wdata_i[DATA_W-1:ADDR_LSB];
        end
    end

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            for (int i = 0; i < NUM_REGS; i++)
                bank_q.slot[i] <= RST_PATTERN[DATA_W-1:ADDR_LSB];
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) rdata_o = {bank_q.slot[i], {ADDR_LSB{1'b0}}};
        end
    end
endmodule

// File: rtl/wpt_addr_bank.sv
module wpt_addr_bank
    import wpt_pkg::*;
#(
    parameter int unsigned NUM_REGS    = 16,
    parameter logic [31:0] RST_PATTERN = 32'h0BAD_F00C
) (
    input  logic        clk,
    input  logic        cold_rst_n,
    input  logic        warm_rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [3:0]  acc_cp,
    input  logic [2:0]  acc_opc1,
    input  logic [3:0]  acc_crn,
    input  logic [3:0]  acc_crm,
    input  logic [2:0]  acc_opc2,
    input  logic [31:0] acc_wdata,
    input  logic [1:0]  priv_lvl,
    input  logic        l2_enabled,
    input  logic        l2_is_64,
    input  logic [1:0]  l2_trap_ctl,
    input  logic        l3_present,
    input  logic        l3_is_64,
    input  logic        l3_trap_bit,
    input  logic        l1_is_32,
    input  logic        os_lock,
    input  logic        halt_allowed,
    input  logic        ext_trap_bit,
    output logic        acc_hit,
    output logic [2:0]  acc_outcome,
    output logic [5:0]  acc_syndrome,
    output logic [31:0] acc_rdata
);
    localparam int unsigned IDX_W    = 4;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_LSB = 2;

    wpt_cfg_t         cfg;
    wpt_outcome_e     outcome;
    logic [SYN_W-1:0] syndrome;
    logic             hit, idx_ok, ok, wr_en;
    logic [DATA_W-1:0] rf_rdata;

    always_comb begin
        cfg.l2_enabled   = l2_enabled;
        cfg.l2_is_64     = l2_is_64;
        cfg.l2_trap_ctl  = l2_trap_ctl;
        cfg.l3_present   = l3_present;
        cfg.l3_is_64     = l3_is_64;
        cfg.l3_trap_bit  = l3_trap_bit;
        cfg.l1_is_32     = l1_is_32;
        cfg.os_lock      = os_lock;
        cfg.halt_allowed = halt_allowed;
        cfg.ext_trap_bit = ext_trap_bit;
    end

    wpt_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
        .valid_i (acc_valid), .cp_i(acc_cp), .opc1_i(acc_opc1), .crn_i(acc_crn),
        .crm_i   (acc_crm), .opc2_i(acc_opc2), .hit_o(hit), .idx_ok_o(idx_ok)
    );

    wpt_perm u_perm (
        .hit_i(hit), .idx_ok_i(idx_ok), .priv_i(priv_lvl), .cfg_i(cfg),
        .outcome_o(outcome), .syndrome_o(syndrome)
    );

    always_comb begin
        ok    = hit && (outcome == OC_OK);
        wr_en = ok && acc_write;
    end

    wpt_regfile #(
        .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .DATA_W(DATA_W),
        .ADDR_LSB(ADDR_LSB), .RST_PATTERN(RST_PATTERN)
    ) u_rf (
        .clk(clk), .cold_rst_n(cold_rst_n), .wr_en_i(wr_en),
        .idx_i(acc_crm), .wdata_i(acc_wdata), .rdata_o(rf_rdata)
    );

    always_comb begin
        acc_hit      = hit;
        acc_outcome  = outcome;
        acc_syndrome = syndrome;
        acc_rdata    = ok ? rf_rdata : '0;
    end

    p_miss_quiet_r1: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !acc_hit |-> (acc_outcome == 3'd0 && acc_rdata == 32'd0 && acc_syndrome == 6'd0));

    p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (!cold_rst_n)
        acc_rdata[1:0] == 2'b00);

    p_bad_index_undef_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (acc_hit && {1'b0, acc_crm} >= 5'(NUM_REGS)) |-> acc_outcome == 3'd1);

    p_level0_undef_r4: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (acc_hit && priv_lvl == 2'd0) |-> acc_outcome == 3'd1);

    p_trap_syndrome_r7: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (acc_outcome inside {3'd2, 3'd3, 3'd4}) |-> acc_syndrome == 6'h05);

    p_plain_syndrome_r7: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !(acc_outcome inside {3'd2, 3'd3, 3'd4}) |-> acc_syndrome == 6'h00);

    p_fail_no_data_r9: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (acc_outcome != 3'd0) |-> acc_rdata == 32'd0);

    p_refused_write_hold_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (acc_hit && acc_write && acc_outcome != 3'd0) |=> $stable(u_rf.bank_q));

    p_warm_hold_r10: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (!warm_rst_n && !acc_valid) |=> $stable(u_rf.bank_q));
endmodule

// File: tb/wpt_addr_bank_tb.sv
module wpt_addr_bank_tb;
    localparam int unsigned NREG = 12;

    logic clk = 1'b0;
    logic cold_rst_n, warm_rst_n;
    logic acc_valid, acc_write;
    logic [3:0] acc_cp, acc_crn, acc_crm;
    logic [2:0] acc_opc1, acc_opc2;
    logic [31:0] acc_wdata;
    logic [1:0] priv_lvl, l2_trap_ctl;
    logic l2_enabled, l2_is_64, l3_present, l3_is_64, l3_trap_bit;
    logic l1_is_32, os_lock, halt_allowed, ext_trap_bit;
    logic acc_hit;
    logic [2:0] acc_outcome;
    logic [5:0] acc_syndrome;
    logic [31:0] acc_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wpt_addr_bank #(.NUM_REGS(NREG)) u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_clear();
        l2_enabled = 0; l2_is_64 = 0; l2_trap_ctl = 2'b00;
        l3_present = 0; l3_is_64 = 0; l3_trap_bit = 0;
        l1_is_32 = 0; os_lock = 0; halt_allowed = 0; ext_trap_bit = 0;
        priv_lvl = 2'd1;
    endtask

    task automatic cfg_all_set();
        l2_enabled = 1; l2_is_64 = 1; l2_trap_ctl = 2'b01;
        l3_present = 1; l3_is_64 = 1; l3_trap_bit = 1;
        l1_is_32 = 1; os_lock = 0; halt_allowed = 1; ext_trap_bit = 1;
    endtask

    task automatic raw(input logic wr, input logic [3:0] cp, input logic [2:0] o1,
                       input logic [3:0] crn, input logic [3:0] crm, input logic [2:0] o2,
                       input logic [31:0] wd, output logic hit, output logic [2:0] oc,
                       output logic [5:0] syn, output logic [31:0] rd);
        @(negedge clk);
        acc_valid = 1; acc_write = wr; acc_cp = cp; acc_opc1 = o1; acc_crn = crn;
        acc_crm = crm; acc_opc2 = o2; acc_wdata = wd;
        #2;
        hit = acc_hit; oc = acc_outcome; syn = acc_syndrome; rd = acc_rdata;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic acc(input logic wr, input logic [3:0] crm, input logic [31:0] wd,
                       output logic [2:0] oc, output logic [5:0] syn, output logic [31:0] rd);
        logic h;
        raw(wr, 4'b1110, 3'd0, 4'd0, crm, 3'b110, wd, h, oc, syn, rd);
    endtask

    task automatic read_clean(input logic [3:0] crm, output logic [31:0] rd);
        logic [2:0] oc; logic [5:0] syn;
        cfg_clear();
        acc(0, crm, 32'd0, oc, syn, rd);
    endtask

    task automatic t_reset();
        #2;
        check("R1 idle hit", {31'd0, acc_hit}, 32'd0);
        check("R1 idle outcome", {29'd0, acc_outcome}, 32'd0);
        check("R1 idle rdata", acc_rdata, 32'd0);
    endtask

    task automatic t_write_read();
        logic [2:0] oc; logic [5:0] syn; logic [31:0] rd;
        cfg_clear();
        acc(1, 4'd0, 32'hFFFF_FFFF, oc, syn, rd);
        check("R8 write success outcome", {29'd0, oc}, 32'd0);
        acc(0, 4'd0, 32'd0, oc, syn, rd);
        check("R2 low bits dropped reg0", rd, 32'hFFFF_FFFC);
        acc(1, 4'd11, 32'h1234_5677, oc, syn, rd);
        acc(1, 4'd5, 32'hA5A5_A5A6, oc, syn, rd);
        acc(0, 4'd11, 32'd0, oc, syn, rd);
        check("R9 read reg11", rd, 32'h1234_5674);
        acc(0, 4'd5, 32'd0, oc, syn, rd);
        check("R2 read reg5", rd, 32'hA5A5_A5A4);
        acc(0, 4'd0, 32'd0, oc, syn, rd);
        check("R9 reg0 kept", rd, 32'hFFFF_FFFC);
    endtask

    task automatic t_decode();
        logic h; logic [2:0] oc; logic [5:0] syn; logic [31:0] rd;
        cfg_clear();
        raw(0, 4'b1101, 3'd0, 4'd0, 4'd5, 3'b110, 0, h, oc, syn, rd);
        check("R1 wrong cp hit", {31'd0, h}, 32'd0);
        check("R1 wrong cp rdata", rd, 32'd0);
        raw(1, 4'b1110, 3'd0, 4'd0, 4'd5, 3'b101, 32'h1111_1110, h, oc, syn, rd);
        check("R1 wrong opc2 hit", {31'd0, h}, 32'd0);
        raw(1, 4'b1110, 3'd1, 4'd0, 4'd5, 3'b110, 32'h2222_2220, h, oc, syn, rd);
        raw(1, 4'b1110, 3'd0, 4'd1, 4'd5, 3'b110, 32'h3333_3330, h, oc, syn, rd);
        read_clean(4'd5, rd);
        check("R1 unrecognised writes ignored", rd, 32'hA5A5_A5A4);
    endtask

    task automatic t_index();
        logic [2:0] oc; logic [5:0] syn; logic [31:0] rd;
        cfg_clear();
        acc(0, 4'd12, 0, oc, syn, rd);
        check("R3 index 12 undef", {29'd0, oc}, 32'd1);
        check("R3 index 12 rdata", rd, 32'd0);
        priv_lvl = 2'd3;
        acc(0, 4'd15, 0, oc, syn, rd);
        check("R3 index 15 undef", {29'd0, oc}, 32'd1);
    endtask

    task automatic t_level0();
        logic [2:0] oc; logic [5:0] syn; logic [31:0] rd;
        cfg_clear();
        priv_lvl = 2'd0;
        acc(0, 4'd0, 0, oc, syn, rd);
        check("R4 level0 read undef", {29'd0, oc}, 32'd1);
        acc(1, 4'd0, 32'h0000_0040, oc, syn, rd);
        check("R4 level0 write undef", {29'd0, oc}, 32'd1);
        read_clean(4'd0, rd);
        check("R8 level0 write refused", rd, 32'hFFFF_FFFC);
    endtask

    task automatic t_level1_chain();
        logic [2:0] oc; logic [5:0] syn; logic [31:0] rd;
        cfg_clear(); cfg_all_set();
        acc(0, 4'd5, 0, oc, syn, rd);
        check("R5 l2 64-bit trap", {29'd0, oc}, 32'd2);
        check("R7 syndrome l2 trap", {26'd0, syn}, 32'h5);
        l2_trap_ctl = 2'b10;
        acc(0, 4'd5, 0, oc, syn, rd);
        check("R5 l2 ctl other bit", {29'd0, oc}, 32'd2);
        l2_is_64 = 0;
        acc(0, 4'd5, 0, oc, syn, rd);
        check("R5 hyp trap", {29'd0, oc}, 32'd3);
        check("R7 syndrome hyp", {26'd0, syn}, 32'h5);
        l2_trap_ctl = 2'b00;
        acc(0, 4'd5, 0, oc, syn, rd);
        check("R5 l3 trap", {29'd0, oc}, 32'd4);
        check("R7 syndrome l3", {26'd0, syn}, 32'h5);
        l3_is_64 = 0;
        acc(1, 4'd5, 32'h7777_7770, oc, syn, rd);
        check("R5 halt", {29'd0, oc}, 32'd5);
        check("R7 syndrome halt zero", {26'd0, syn}, 32'h0);
        os_lock = 1;
        acc(0, 4'd5, 0, oc, syn, rd);
        check("R5 chain passes", {29'd0, oc}, 32'd0);
        check("R8 halted write refused", rd, 32'hA5A5_A5A4);
    endtask

    task automatic t_level23();
        logic [2:0] oc; logic [5:0] syn; logic [31:0] rd;
        cfg_clear(); cfg_all_set();
        priv_lvl = 2'd2;
        acc(0, 4'd1, 0, oc, syn, rd);
        check("R6 level2 skips l2 traps", {29'd0, oc}, 32'd4);
        l3_trap_bit = 0;
        acc(0, 4'd1, 0, oc, syn, rd);
        check("R6 level2 halt", {29'd0, oc}, 32'd5);
        l3_trap_bit = 1;
        priv_lvl = 2'd3;
        acc(0, 4'd1, 0, oc, syn, rd);
        check("R6 level3 only halt", {29'd0, oc}, 32'd5);
        halt_allowed = 0;
        acc(1, 4'd1, 32'hCAFE_0003, oc, syn, rd);
        check("R6 level3 passes", {29'd0, oc}, 32'd0);
        acc(0, 4'd1, 0, oc, syn, rd);
        check("R2 level3 write stored", rd, 32'hCAFE_0000);
    endtask

    task automatic t_warm();
        logic [2:0] oc; logic [5:0] syn; logic [31:0] rd;
        cfg_clear();
        acc(1, 4'd7, 32'h8000_1234, oc, syn, rd);
        @(negedge clk); warm_rst_n = 0;
        repeat (3) @(negedge clk);
        warm_rst_n = 1;
        read_clean(4'd7, rd);
        check("R10 warm reset keeps reg7", rd, 32'h8000_1234);
    endtask

    initial begin
        cold_rst_n = 0; warm_rst_n = 1;
        acc_valid = 0; acc_write = 0; acc_cp = 0; acc_opc1 = 0; acc_crn = 0;
        acc_crm = 0; acc_opc2 = 0; acc_wdata = 0;
        cfg_clear();
        repeat (3) @(negedge clk);
        cold_rst_n = 1;
        t_reset();
        t_write_read();
        t_decode();
        t_index();
        t_level0();
        t_level1_chain();
        t_level23();
        t_warm();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule